// File: doc/BRIEF.md
# Receive Frame Validity Filter

This block sits behind a receive MAC and passes judgement on every incoming frame. Bytes arrive one per qualified beat. The first byte is marked with a start flag and the last byte with an end flag. On the end beat the FCS checker reports whether the CRC matched, and a select input picks one of two maximum lengths: the untagged limit or the VLAN-tagged limit. The filter counts the bytes of the frame, from the first destination-address byte through the last FCS byte. On the end beat it raises either an accept strobe or a discard strobe.

A discarded frame also raises exactly one increment strobe, which goes to the statistics counter for its error class: undersized, oversized or bad CRC. A clean frame raises no increment strobe. The length count saturates just above the longer limit, so a runaway frame cannot wrap the count into the legal range. All strobes are combinational on the end beat, so the buffer manager can release or commit the frame in the same cycle.

Top module: `rx_frame_filter`

## Requirements
- R1: The frame length is the number of beats with `in_valid` high from the start beat through the end beat inclusive, and cycles with `in_valid` low add nothing to it.
- R2: A frame of fewer than 64 bytes raises `frame_discard` and `runt_inc` on its end beat.
- R3: A frame longer than the selected limit raises `frame_discard` and `oversize_inc`. The limit is 1518 bytes when `long_sel` is 0 and 1522 bytes when `long_sel` is 1, so lengths of 1519 to 1522 are legal only when `long_sel` is 1.
- R4: A frame of legal length whose `fcs_ok` is low on the end beat raises `frame_discard` and `badfcs_inc`.
- R5: Length errors take precedence over a CRC error. A short frame with a bad CRC raises only `runt_inc`, and an overlong frame raises only `oversize_inc` whatever `fcs_ok` is.
- R6: The length count saturates above the longer limit, so a frame of any length beyond the limit, even thousands of bytes, is reported as oversize.
- R7: Each end beat raises exactly one of `frame_accept` and `frame_discard`. No other cycle raises any output, and an accepted frame raises no increment strobe.
- R8: After reset all outputs are low and the count starts from zero. A start beat that arrives in the middle of a frame restarts the count at one for the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat qualifier: one byte of the frame this cycle |
| in_sof | input | 1 | The current beat is the first byte of a frame |
| in_eof | input | 1 | The current beat is the last byte of a frame |
| fcs_ok | input | 1 | CRC verdict from the FCS checker, sampled on the end beat |
| long_sel | input | 1 | 0 selects the 1518-byte limit, 1 selects the 1522-byte limit |
| frame_accept | output | 1 | The frame ending this beat is kept |
| frame_discard | output | 1 | The frame ending this beat is dropped |
| runt_inc | output | 1 | Increment strobe for the undersized-frame counter |
| oversize_inc | output | 1 | Increment strobe for the oversized-frame counter |
| badfcs_inc | output | 1 | Increment strobe for the bad-CRC counter |

## Verification
The only internal state is the byte count. A wrong count stays hidden until the next end beat and shows there as a wrong verdict. A count that is off by one appears only when the frame length sits right at 64, 1518 or 1522 bytes, so frames at those lengths and one byte either side are exercised with both limit selections. A count that fails to saturate or fails to restart shows up as an overlong frame accepted, or as a frame that follows an abandoned one being misjudged. Frames with idle gaps, single-beat frames and very long frames carry these faults to the strobes at the end of the frame that exposes them.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic [1:0] {
      CLS_GOOD   = 2'd0,
      CLS_RUNT   = 2'd1,
      CLS_OVER   = 2'd2,
      CLS_BADFCS = 2'd3
   } rxf_cls_e;
endpackage

// File: rtl/rxf_len_counter.sv
module rxf_len_counter #(
   parameter int CW    = 11,
   parameter int SAT   = 1523
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          beat,
   input  logic          sof,
   input  logic          eof,
   output logic [CW-1:0] len_now
);
   localparam logic [CW-1:0] SAT_V = CW'(SAT);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_inc;

   always_comb begin
      cnt_inc = (cnt_q >= SAT_V) ? SAT_V : cnt_q + 1'b1;
      len_now = sof ? CW'(1) : cnt_inc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (beat)
         cnt_q <= eof ? '0 : len_now;
   end

   // R1
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && eof) |=> (cnt_q == '0));

   // R6
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !sof && !eof && cnt_q == SAT_V) |=> (cnt_q == SAT_V));

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= SAT_V);
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
   import rxf_pkg::*;
#(
   parameter int CW      = 11,
   parameter int MIN_LEN = 64,
   parameter int MAX_STD = 1518,
   parameter int MAX_TAG = 1522
) (
   input  logic [CW-1:0] len,
   input  logic          long_sel,
   input  logic          fcs_ok,
   output rxf_cls_e      cls
);
   localparam logic [CW-1:0] MIN_V = CW'(MIN_LEN);
   localparam logic [CW-1:0] STD_V = CW'(MAX_STD);
   localparam logic [CW-1:0] TAG_V = CW'(MAX_TAG);

   logic [CW-1:0] limit;

   generate
      if (MAX_TAG == MAX_STD) begin : g_one_limit
         logic unused_sel;
         assign unused_sel = long_sel;
         assign limit      = STD_V;
      end else begin : g_two_limits
         assign limit = long_sel ? TAG_V : STD_V;
      end
   endgenerate

   always_comb begin
      if (len > limit)
         cls = CLS_OVER;
      else if (len < MIN_V)
         cls = CLS_RUNT;
      else if (!fcs_ok)
         cls = CLS_BADFCS;
      else
         cls = CLS_GOOD;
   end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import rxf_pkg::*;
(
   input  logic     end_beat,
   input  rxf_cls_e cls,
   output logic     accept,
   output logic     discard,
   output logic     runt_inc,
   output logic     over_inc,
   output logic     bad_inc
);
   always_comb begin
      accept   = end_beat && (cls == CLS_GOOD);
      discard  = end_beat && (cls != CLS_GOOD);
      runt_inc = end_beat && (cls == CLS_RUNT);
      over_inc = end_beat && (cls == CLS_OVER);
      bad_inc  = end_beat && (cls == CLS_BADFCS);
   end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
   import rxf_pkg::*;
#(
   parameter int MIN_LEN = 64,
   parameter int MAX_STD = 1518,
   parameter int MAX_TAG = 1522
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_sof,
   input  logic in_eof,
   input  logic fcs_ok,
   input  logic long_sel,
   output logic frame_accept,
   output logic frame_discard,
   output logic runt_inc,
   output logic oversize_inc,
   output logic badfcs_inc
);
   localparam int SAT = MAX_TAG + 1;
   localparam int CW  = $clog2(SAT + 1);

   generate
      if (MIN_LEN < 2 || MIN_LEN >= MAX_STD || MAX_STD > MAX_TAG) begin : g_bad_cfg
         $error("rx_frame_filter: need 2 <= MIN_LEN < MAX_STD <= MAX_TAG");
      end
   endgenerate

   logic          beat;
   logic          end_beat;
   logic [CW-1:0] len_now;
   rxf_cls_e      cls;

   assign beat     = in_valid;
   assign end_beat = in_valid && in_eof;

   rxf_len_counter #(.CW(CW), .SAT(SAT)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat    (beat),
      .sof     (in_sof),
      .eof     (in_eof),
      .len_now (len_now)
   );

   rxf_classify #(.CW(CW), .MIN_LEN(MIN_LEN), .MAX_STD(MAX_STD), .MAX_TAG(MAX_TAG)) u_cls (
      .len      (len_now),
      .long_sel (long_sel),
      .fcs_ok   (fcs_ok),
      .cls      (cls)
   );

   rxf_decide u_dec (
      .end_beat (end_beat),
      .cls      (cls),
      .accept   (frame_accept),
      .discard  (frame_discard),
      .runt_inc (runt_inc),
      .over_inc (oversize_inc),
      .bad_inc  (badfcs_inc)
   );

   // R7
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_beat |-> ($countones({frame_accept, frame_discard}) == 1));

   // R7
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !end_beat |-> !(frame_accept || frame_discard || runt_inc || oversize_inc || badfcs_inc));

   // R5
   single_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({runt_inc, oversize_inc, badfcs_inc}));

   // R7
   discard_has_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_discard |-> (runt_inc || oversize_inc || badfcs_inc));

   // R4
   accept_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_accept |-> fcs_ok);
endmodule

// File: tb/rx_frame_filter_tb_top.sv
module rx_frame_filter_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, fcs_ok = 1'b0, long_sel = 1'b0;
   logic frame_accept, frame_discard, runt_inc, oversize_inc, badfcs_inc;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;
   bit done = 1'b0;
   int ref_len = 0;

   always #10 clk = ~clk;

   rx_frame_filter dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .fcs_ok(fcs_ok), .long_sel(long_sel), .frame_accept(frame_accept),
      .frame_discard(frame_discard), .runt_inc(runt_inc), .oversize_inc(oversize_inc),
      .badfcs_inc(badfcs_inc)
   );

   function automatic logic [4:0] expect_vec(int len, bit fcs, bit sel);
      int lim;
      lim = sel ? 1522 : 1518;
      if (len > lim)     return 5'b01010;
      else if (len < 64) return 5'b01100;
      else if (!fcs)     return 5'b01001;
      else               return 5'b10000;
   endfunction

   task automatic compare(logic [4:0] exp, string tag);
      logic [4:0] act;
      act = {frame_accept, frame_discard, runt_inc, oversize_inc, badfcs_inc};
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: outputs {acc,dis,runt,over,bad} actual %b expected %b (len %0d)",
                  tag, act, exp, ref_len);
      end
   endtask

   task automatic step(bit v, bit s, bit e, bit f, string tag);
      int len;
      logic [4:0] exp;
      @(negedge clk);
      in_valid = v; in_sof = s; in_eof = e; fcs_ok = f;
      #5;
      exp = 5'b0;
      len = ref_len;
      if (v) begin
         len = s ? 1 : ref_len + 1;
         if (e) exp = expect_vec(len, f, long_sel);
      end
      compare(exp, (v && e) ? tag : "R7");
      if (v) ref_len = e ? 0 : len;
   endtask

   task automatic send_frame(int n, bit f, int gap_every, string tag);
      for (int i = 0; i < n; i++) begin
         if (gap_every > 0 && i > 0 && (i % gap_every) == 0) step(1'b0, 1'b0, 1'b0, 1'b0, tag);
         step(1'b1, i == 0, i == n - 1, f, tag);
      end
      step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         mismatched++;
         $display("FAIL R7: watchdog expired, actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      #5 compare(5'b0, "R8");
      @(negedge clk) rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
      long_sel = 1'b0;
      send_frame(63, 1'b1, 0, "R2");
      send_frame(64, 1'b1, 0, "R1");
      send_frame(64, 1'b1, 7, "R1");
      send_frame(64, 1'b0, 0, "R4");
      send_frame(200, 1'b0, 13, "R4");
      send_frame(10, 1'b0, 0, "R5");
      send_frame(1, 1'b1, 0, "R2");
      send_frame(1518, 1'b1, 0, "R3");
      send_frame(1519, 1'b1, 0, "R3");
      send_frame(1519, 1'b0, 0, "R5");
      long_sel = 1'b1;
      send_frame(1519, 1'b1, 0, "R3");
      send_frame(1522, 1'b1, 0, "R3");
      send_frame(1522, 1'b0, 0, "R4");
      send_frame(1523, 1'b1, 0, "R3");
      send_frame(3100, 1'b1, 0, "R6");
      send_frame(5000, 1'b0, 0, "R6");
      send_frame(100, 1'b1, 0, "R1");
      // R8: abandoned frame, then restart by a new start beat
      for (int i = 0; i < 30; i++) step(1'b1, i == 0, 1'b0, 1'b1, "R8");
      send_frame(70, 1'b1, 0, "R8");
      for (int i = 0; i < 1600; i++) step(1'b1, i == 0, 1'b0, 1'b1, "R8");
      send_frame(40, 1'b1, 0, "R8");
      send_frame(64, 1'b1, 0, "R7");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule